// File: doc/BRIEF.md
# Random TLB Replacement Index Generator

This block picks a victim slot for a software-managed translation buffer. The lowest slots are pinned and must never be chosen. The pinned count is the wired boundary, and the total slot count is the buffer size. On each accepted request the block steps a 32-bit right-shifting pseudo-random register. It reduces that value modulo the number of unpinned slots and adds the wired count to the remainder. The result is an index in the range from the wired count up to the size minus one.

The block never hands out the same index on two successive requests. When a candidate matches the index returned last time, the random register steps again and the reduction is repeated. The reduction is done by a serial restoring divider, so one candidate costs about 33 cycles. A one-cycle valid pulse marks the result. The ready output is low while a request is being served. When at most one unpinned slot exists, the wired count is returned at once, which keeps the retry loop from spinning forever.

Top module: `tlb_victim_picker`

## Requirements
- R1: After reset, ready_o is 1 and valid_o is 0. The random register holds 1 and the last-returned index holds 0.
- R2: Each step of the random register shifts it right by one bit. When the bit that leaves at position 0 was 1, the shifted value is XORed with 32'hD0000001. A register that holds 1 therefore steps to 32'hD0000001.
- R3: For a request with wired count W and size S where S > W+1, each candidate is (stepped register value mod (S−W)) + W. The returned index lies in [W, S−1].
- R4: When S > W+1, a candidate equal to the previously returned index is dropped. The register steps again until a different candidate appears. The returned index then becomes the new previous index.
- R5: When S ≤ W+1, the index returned is W itself. valid_o rises on the clock edge after acceptance. The random register does not step, and the previous index becomes W.
- R6: A request is accepted only while ready_o is 1. After a non-degenerate acceptance, ready_o stays 0 until the result is given, and requests in that window produce no result.
- R7: Every accepted request produces exactly one valid_o cycle, and valid_o is never 1 without an accepted request.
- R8: The wired count and size are sampled on the acceptance edge. Changes to wired_i or size_i while a request is in progress do not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request for a new victim index |
| wired_i | input | 7 | Number of pinned low slots |
| size_i | input | 7 | Total slot count, at most 64 |
| ready_o | output | 1 | Block can accept a request |
| valid_o | output | 1 | One-cycle pulse, index_o is valid |
| index_o | output | 6 | Chosen victim index |

## Verification
Two functions can fall in the same cycle. A fresh candidate can be produced, and in that same cycle the candidate is found to equal the previous index, so the random register must step and the divider must restart at once. A span of two unpinned slots provokes this often, because every other candidate repeats. The bench runs long streams at that span and at wider ones. Each index is judged against a bench-side model of the register and of the retry rule. A second case puts a pending request next to changed inputs and new request pulses while the block is busy. That case checks that neither the latched bounds nor the result count are disturbed.

// File: rtl/tlbvp_pkg.sv
// Shared constants and types for the victim index generator.
// Assumes a 32-bit random register; the feedback mask is fixed here.
package tlbvp_pkg;
    localparam int          RND_W    = 32;
    localparam logic [31:0] RND_MASK = 32'hD000_0001;
    localparam logic [31:0] RND_SEED = 32'h0000_0001;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_BUSY = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/vp_rnd.sv
// Right-shifting feedback register with a fixed XOR mask.
// It steps when step_i is high and reports the value it steps to, so
// the consumer can use that value in the same cycle as the step.
module vp_rnd
    import tlbvp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [RND_W-1:0] next_o
);
    logic [RND_W-1:0] cur_q;

    // Next value: shift right, fold in the mask when bit 0 leaves as 1.
    always_comb begin
        next_o = (cur_q >> 1) ^ (cur_q[0] ? RND_MASK : '0);
    end

    // State register, seeded at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= RND_SEED;
        end else if (step_i) begin
            cur_q <= next_o;
        end
    end
endmodule

// File: rtl/vp_moddiv.sv
// Serial restoring remainder unit: one dividend bit per cycle.
// Assumes divisor_i is nonzero and at most 2**(DIV_W-1); it is held
// stable by the caller from load_i until done_o. done_o is a one-cycle pulse
// after the last bit, with rem_o valid in that cycle.
module vp_moddiv #(
    parameter int DVD_W = 32,
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DIV_W-1:0] rem_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DIV_W-1:0] rem_q;
    logic [CNT_W-1:0] left_q;
    logic             busy_q;
    logic             done_q;
    logic [DIV_W:0]   trial;
    logic [DIV_W:0]   diff;
    logic [DIV_W-1:0] rem_nx;

    // One restoring step: bring in the next dividend bit, subtract if it fits.
    always_comb begin
        trial  = {rem_q, dvd_q[DVD_W-1]};
        diff   = trial - {1'b0, divisor_i};
        rem_nx = (trial >= {1'b0, divisor_i}) ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
    end

    // Iteration control and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            rem_q  <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                dvd_q  <= dividend_i;
                rem_q  <= '0;
                left_q <= CNT_W'(DVD_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= rem_nx;
                dvd_q  <= dvd_q << 1;
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign rem_o  = rem_q;
endmodule

// File: rtl/vp_ctrl.sv
// Request sequencer: latches the bounds, starts candidate computations,
// rejects repeats of the last index and issues the result pulse.
// Assumes the remainder unit answers with one done pulse per load.
module vp_ctrl
    import tlbvp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] wired_i,
    input  logic [CNT_W-1:0] size_i,
    input  logic             div_done_i,
    input  logic [CNT_W-1:0] div_rem_i,
    output logic             step_o,
    output logic             div_load_o,
    output logic [CNT_W-1:0] span_o,
    output logic             ready_o,
    output logic             valid_o,
    output logic [IDX_W-1:0] index_o
);
    ctl_state_t       st_q;
    logic [CNT_W-1:0] wired_q;
    logic [CNT_W-1:0] span_q;
    logic [IDX_W-1:0] prev_q;
    logic             valid_q;
    logic [IDX_W-1:0] index_q;
    logic             accept;
    logic             narrow;
    logic [CNT_W-1:0] cand;
    logic             repeat_hit;

    // Decode acceptance, the narrow-range case and the candidate compare.
    always_comb begin
        accept     = req_i && (st_q == CTL_IDLE);
        narrow     = {1'b0, size_i} <= ({1'b0, wired_i} + 1'b1);
        cand       = div_rem_i + wired_q;
        repeat_hit = cand == {{(CNT_W-IDX_W){1'b0}}, prev_q};
        step_o     = (accept && !narrow) ||
                     ((st_q == CTL_BUSY) && div_done_i && repeat_hit);
        div_load_o = step_o;
    end

    // Sequencer state, latched bounds, last index and result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CTL_IDLE;
            wired_q <= '0;
            span_q  <= CNT_W'(1);
            prev_q  <= '0;
            valid_q <= 1'b0;
            index_q <= '0;
        end else begin
            valid_q <= 1'b0;
            case (st_q)
                CTL_IDLE: begin
                    if (accept) begin
                        if (narrow) begin
                            index_q <= wired_i[IDX_W-1:0];
                            prev_q  <= wired_i[IDX_W-1:0];
                            valid_q <= 1'b1;
                        end else begin
                            wired_q <= wired_i;
                            span_q  <= size_i - wired_i;
                            st_q    <= CTL_BUSY;
                        end
                    end
                end
                CTL_BUSY: begin
                    if (div_done_i && !repeat_hit) begin
                        index_q <= cand[IDX_W-1:0];
                        prev_q  <= cand[IDX_W-1:0];
                        valid_q <= 1'b1;
                        st_q    <= CTL_IDLE;
                    end
                end
                default: st_q <= CTL_IDLE;
            endcase
        end
    end

    assign span_o  = span_q;
    assign ready_o = (st_q == CTL_IDLE);
    assign valid_o = valid_q;
    assign index_o = index_q;
endmodule

// File: rtl/tlb_victim_picker.sv
// Top of the victim index generator. It joins the random register, the
// serial remainder unit and the sequencer. Assumes ENTRY_MAX is a power
// of two and that wired_i < size_i <= ENTRY_MAX for meaningful results.
module tlb_victim_picker
    import tlbvp_pkg::*;
#(
    parameter int ENTRY_MAX = 64,
    localparam int IDX_W    = $clog2(ENTRY_MAX),
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] wired_i,
    input  logic [CNT_W-1:0] size_i,
    output logic             ready_o,
    output logic             valid_o,
    output logic [IDX_W-1:0] index_o
);
    logic             step;
    logic             div_load;
    logic             div_done;
    logic [CNT_W-1:0] div_rem;
    logic [CNT_W-1:0] span;
    logic [RND_W-1:0] rnd_next;

    vp_rnd u_rnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .next_o (rnd_next)
    );

    vp_moddiv #(.DVD_W(RND_W), .DIV_W(CNT_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .dividend_i (rnd_next),
        .divisor_i  (span),
        .done_o     (div_done),
        .rem_o      (div_rem)
    );

    vp_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .wired_i    (wired_i),
        .size_i     (size_i),
        .div_done_i (div_done),
        .div_rem_i  (div_rem),
        .step_o     (step),
        .div_load_o (div_load),
        .span_o     (span),
        .ready_o    (ready_o),
        .valid_o    (valid_o),
        .index_o    (index_o)
    );
endmodule

// File: rtl/vp_chk.sv
// Port-level checker for the victim index generator. It keeps its own copy
// of the latched bounds, the last index and the pending-result flag.
module vp_chk #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic [CNT_W-1:0] wired_i,
    input logic [CNT_W-1:0] size_i,
    input logic             ready_o,
    input logic             valid_o,
    input logic [IDX_W-1:0] index_o
);
    logic [CNT_W-1:0] w_q;
    logic [CNT_W-1:0] s_q;
    logic [IDX_W-1:0] last_q;
    logic             pend_q;
    logic             acc;
    logic             wide_q;

    assign acc = req_i && ready_o;

    // Shadow of the bounds, the last index and the outstanding request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= '0;
            s_q    <= '0;
            last_q <= '0;
            pend_q <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            if (acc) begin
                w_q    <= wired_i;
                s_q    <= size_i;
                wide_q <= {1'b0, size_i} > ({1'b0, wired_i} + 1'b1);
            end
            if (valid_o) last_q <= index_o;
            if (acc) pend_q <= 1'b1;
            else if (valid_o) pend_q <= 1'b0;
        end
    end

    // R3
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && wide_q) |-> ({1'b0, index_o} >= w_q && {1'b0, index_o} < s_q));

    // R4
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && wide_q) |-> (index_o != last_q));

    // R5
    narrow_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ({1'b0, size_i} <= ({1'b0, wired_i} + 1'b1)))
        |=> (valid_o && {1'b0, index_o} == $past(wired_i)));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ({1'b0, size_i} > ({1'b0, wired_i} + 1'b1))) |=> !ready_o);

    // R7
    valid_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_q);
endmodule

bind tlb_victim_picker vp_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_vp_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .wired_i (wired_i),
    .size_i  (size_i),
    .ready_o (ready_o),
    .valid_o (valid_o),
    .index_o (index_o)
);

// File: tb/tb_tlb_victim_picker.sv
module tb_tlb_victim_picker;
    localparam int IDX_W = 6;
    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic [CNT_W-1:0] wired_i = '0;
    logic [CNT_W-1:0] size_i = 7'd64;
    logic             ready_o;
    logic             valid_o;
    logic [IDX_W-1:0] index_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_rnd;
    int unsigned m_prev;

    always #4 clk = ~clk;

    tlb_victim_picker dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .wired_i (wired_i),
        .size_i  (size_i),
        .ready_o (ready_o),
        .valid_o (valid_o),
        .index_o (index_o)
    );

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Bench model of the expected index (R2 step rule, R3 mapping, R4 retry, R5 narrow).
    function automatic int unsigned model_pick(input int unsigned w, input int unsigned s);
        int unsigned cand;
        if (s <= w + 1) begin
            cand = w;
        end else begin
            do begin
                m_rnd = (m_rnd >> 1) ^ (m_rnd[0] ? 32'hD000_0001 : 32'h0);
                cand  = (m_rnd % (s - w)) + w;
            end while (cand == m_prev);
        end
        m_prev = cand;
        return cand;
    endfunction

    // Issue one request, wait for the result and check it.
    task automatic request(input int unsigned w, input int unsigned s, input string tag);
        int unsigned exp;
        int wait_n;
        exp = model_pick(w, s);
        @(negedge clk);
        wired_i = CNT_W'(w);
        size_i  = CNT_W'(s);
        req_i   = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wait_n = 0;
        while (!valid_o && wait_n < 3000) begin
            @(negedge clk);
            wait_n++;
        end
        check({tag, " result arrives"}, valid_o === 1'b1, int'(valid_o), 1);
        check({tag, " index"}, int'(index_o) == int'(exp), int'(index_o), int'(exp));
        @(negedge clk);
        check("R7 single valid cycle", valid_o === 1'b0, int'(valid_o), 0);
    endtask

    task automatic t_reset();
        check("R1 ready after reset", ready_o === 1'b1, int'(ready_o), 1);
        check("R1 valid low after reset", valid_o === 1'b0, int'(valid_o), 0);
    endtask

    // R2: first index from seed 1 and previous index 0.
    task automatic t_first();
        request(0, 64, "R2 first pick");
    endtask

    // R3/R4 across several bounds.
    task automatic t_sweep();
        for (int i = 0; i < 12; i++) request(0, 64, "R3 full range");
        for (int i = 0; i < 12; i++) request(5, 13, "R3 offset range");
        for (int i = 0; i < 10; i++) request(40, 47, "R3 high range");
    endtask

    // R4: two free slots force frequent retries and strict alternation.
    task automatic t_pair();
        for (int i = 0; i < 16; i++) request(10, 12, "R4 pair span");
    endtask

    // R5: narrow ranges return the wired count and leave the register alone.
    task automatic t_narrow();
        @(negedge clk);
        wired_i = 7'd20;
        size_i  = 7'd21;
        req_i   = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check("R5 narrow next-cycle valid", valid_o === 1'b1, int'(valid_o), 1);
        check("R5 narrow index", int'(index_o) == 20, int'(index_o), 20);
        m_prev = 20;
        @(negedge clk);
        check("R7 narrow single valid", valid_o === 1'b0, int'(valid_o), 0);
        request(30, 30, "R5 empty span");
        request(0, 64, "R5 register untouched");
    endtask

    // R6/R7/R8: pulses and input changes while busy.
    task automatic t_busy();
        int unsigned exp;
        int vcount;
        exp = model_pick(3, 9);
        @(negedge clk);
        wired_i = 7'd3;
        size_i  = 7'd9;
        req_i   = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check("R6 ready low when busy", ready_o === 1'b0, int'(ready_o), 0);
        wired_i = 7'd50;
        size_i  = 7'd51;
        vcount = 0;
        for (int i = 0; i < 20; i++) begin
            req_i = i[0];
            @(negedge clk);
        end
        req_i = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (valid_o) begin
                vcount++;
                check("R8 latched bounds", int'(index_o) == int'(exp), int'(index_o), int'(exp));
            end
            @(negedge clk);
        end
        check("R6 one result for busy window", vcount == 1, vcount, 1);
        check("R6 ready back after result", ready_o === 1'b1, int'(ready_o), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_rnd  = 32'h1;
        m_prev = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first();
        t_sweep();
        t_pair();
        t_narrow();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule